// File: doc/BRIEF.md
# FIFO Event DMA Trigger Selector

This block turns activity on a receive FIFO and a transmit FIFO into single-cycle DMA request pulses. It watches each FIFO's read and write strobes, its fill level before the operation, its empty and full flags, a programmable threshold, and five transaction-operation strobes: reset, deallocate, retry, discard and commit. From these it derives a set of named events for each FIFO. It does not hold the FIFO storage, and it does not interpret what the operations mean.

There are `NCH` trigger channels, two by default. Each channel has its own 5-bit selection register, written and read over a small byte-wide configuration port. Bit 4 of the selection code picks the FIFO: 0 selects receive and 1 selects transmit. The low nibble picks the event, and its meaning is the same for both FIFOs. Every channel registers its chosen event, so a request appears on `dma_trig` in the clock cycle after the event's inputs are presented, and it lasts exactly one cycle.

Top module: `fifo_evt_trigsel`

## Requirements
- R1: On a synchronous active-high reset, every selection register clears to 0x00, `dma_trig` goes low on the next cycle, and a read of any channel returns 0x00.
- R2: A write with `cfg_we` high stores `cfg_wdata[4:0]` into the selection register of channel `cfg_addr`. A read returns that value in `cfg_rdata` one cycle after `cfg_addr` is presented, with bits 7:5 always zero. Other channels are left unchanged.
- R3: Selection bit 4 picks the FIFO: 0 selects the receive FIFO (index 0 of every per-FIFO port) and 1 selects the transmit FIFO (index 1). Events on the other FIFO do not fire the channel.
- R4: Low nibble 0x1 (data available) fires on a read while the level is above 1, or on a write while the level is 0.
- R5: Low nibble 0x2 (space available) fires on a write while the level is below DEPTH-1, or on a read while the level equals DEPTH.
- R6: Low nibble 0x3 fires once when the empty flag rises, and 0x4 fires once when the full flag rises. A flag that stays high gives no further pulses.
- R7: Low nibble 0x5 fires on a write when the length after the operation (level + write - read) equals the FIFO's threshold.
- R8: Low nibble 0x6 fires on a read while the level equals the threshold.
- R9: Low nibbles 0x7, 0x8, 0x9, 0xA and 0xB fire on the reset, deallocate, retry, discard and commit strobes of the selected FIFO, in that order.
- R10: Low nibbles 0x0 and 0xC to 0xF never fire, whatever the inputs do.
- R11: Each channel's pulse is registered. It is high for one cycle, in the cycle after the triggering inputs. Channels work independently and may fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Selection register write enable |
| cfg_addr | input | ADDR_W | Channel index for writes and reads |
| cfg_wdata | input | 8 | Write data; bits 4:0 are stored |
| cfg_rdata | output | 8 | Registered read data, bits 7:5 zero |
| fifo_rd | input | 2 | Read strobe per FIFO (0 receive, 1 transmit) |
| fifo_wr | input | 2 | Write strobe per FIFO |
| fifo_level | input | 2 x LVL_W | Fill level per FIFO, before this cycle's operation |
| fifo_thresh | input | 2 x LVL_W | Threshold per FIFO |
| fifo_empty | input | 2 | Empty flag per FIFO |
| fifo_full | input | 2 | Full flag per FIFO |
| op_reset | input | 2 | Reset operation strobe per FIFO |
| op_dealloc | input | 2 | Deallocate operation strobe per FIFO |
| op_retry | input | 2 | Retry operation strobe per FIFO |
| op_discard | input | 2 | Discard operation strobe per FIFO |
| op_commit | input | 2 | Commit operation strobe per FIFO |
| dma_trig | output | NCH | One-cycle DMA request per channel |

## Verification
The bench targets the boundaries of the level conditions:
- A read of the last byte and a write that fills the last free slot must stay silent. A design that compared against the wrong bound would fire on them.
- A write at the threshold must stay silent, and so must a read that lands the length on the threshold. A design that mixed up pre- and post-operation length would fire on one of these or miss the real match.

Empty and full flags are held high over several cycles. A level-sensitive design would repeat the pulse there.

The bench also checks FIFO selection, in two ways:
- An event on the unselected FIFO must leave the channel low.
- Every operation code is driven next to its neighbouring strobe, so a design with a shifted operation order would fire on the wrong strobe.

Finally, every strobe and flag is driven at once under the never codes. A design that decoded bit 4 or the reserved nibbles loosely would fire there.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

  localparam int SEL_W  = 5;
  localparam int NUM_EV = 16;
  localparam int NFIFO  = 2;

  typedef logic [NUM_EV-1:0] ev_vec_t;

  typedef enum logic [3:0] {
    EV_NONE     = 4'h0,
    EV_DATA     = 4'h1,
    EV_SPACE    = 4'h2,
    EV_EMPTY    = 4'h3,
    EV_FULL     = 4'h4,
    EV_THR_WR   = 4'h5,
    EV_THR_RD   = 4'h6,
    EV_OP_RST   = 4'h7,
    EV_OP_DEALL = 4'h8,
    EV_OP_RETRY = 4'h9,
    EV_OP_DISC  = 4'hA,
    EV_OP_COMM  = 4'hB
  } ev_code_e;

endpackage

// File: rtl/fdt_event_detect.sv
module fdt_event_detect
  import fdt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic             wr,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  input  logic             empty,
  input  logic             full,
  input  logic             op_reset,
  input  logic             op_dealloc,
  input  logic             op_retry,
  input  logic             op_discard,
  input  logic             op_commit,
  output ev_vec_t          events
);

  logic           empty_q;
  logic           full_q;
  logic           empty_rise;
  logic           full_rise;
  logic [LVL_W:0] len_after;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      empty_q <= empty;
      full_q  <= full;
    end
  end

  assign empty_rise = empty & ~empty_q;
  assign full_rise  = full & ~full_q;
  assign len_after  = {1'b0, level} + (LVL_W+1)'(wr) - (LVL_W+1)'(rd);

  always_comb begin
    events              = '0;
    events[EV_DATA]     = (rd && (level > LVL_W'(1))) || (wr && (level == '0));
    events[EV_SPACE]    = (wr && (level < LVL_W'(DEPTH-1))) || (rd && (level == LVL_W'(DEPTH)));
    events[EV_EMPTY]    = empty_rise;
    events[EV_FULL]     = full_rise;
    events[EV_THR_WR]   = wr && (len_after == {1'b0, thresh});
    events[EV_THR_RD]   = rd && (level == thresh);
    events[EV_OP_RST]   = op_reset;
    events[EV_OP_DEALL] = op_dealloc;
    events[EV_OP_RETRY] = op_retry;
    events[EV_OP_DISC]  = op_discard;
    events[EV_OP_COMM]  = op_commit;
  end

  // R6
  empty_once_chk: assert property (@(posedge clk) disable iff (rst)
    events[EV_EMPTY] |=> !events[EV_EMPTY]);

  // R6
  full_once_chk: assert property (@(posedge clk) disable iff (rst)
    events[EV_FULL] |=> !events[EV_FULL]);

endmodule

// File: rtl/fdt_chan.sv
module fdt_chan
  import fdt_pkg::*;
#(
  parameter int ADDR_W = 1,
  parameter int CH_IDX = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [7:0]            cfg_wdata,
  input  ev_vec_t [NFIFO-1:0]   evs,
  output logic [SEL_W-1:0]      sel_o,
  output logic                  trig_o
);

  logic [SEL_W-1:0] sel_q;
  logic             hit;
  logic             picked;

  assign hit    = cfg_we && (cfg_addr == ADDR_W'(CH_IDX));
  assign picked = evs[sel_q[SEL_W-1]][sel_q[SEL_W-2:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      trig_o <= 1'b0;
    end else begin
      if (hit) sel_q <= cfg_wdata[SEL_W-1:0];
      trig_o <= picked;
    end
  end

  assign sel_o = sel_q;

  // R10
  never_code_chk: assert property (@(posedge clk) disable iff (rst)
    ((sel_q[3:0] == 4'h0) || (sel_q[3:0] >= 4'hC)) |=> !trig_o);

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && (cfg_addr == ADDR_W'(CH_IDX))) |=> $stable(sel_q));

endmodule

// File: rtl/fifo_evt_trigsel.sv
module fifo_evt_trigsel
  import fdt_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int NCH    = 2,
  localparam int LVL_W  = $clog2(DEPTH+1),
  localparam int ADDR_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [7:0]                  cfg_wdata,
  output logic [7:0]                  cfg_rdata,
  input  logic [1:0]                  fifo_rd,
  input  logic [1:0]                  fifo_wr,
  input  logic [1:0][LVL_W-1:0]       fifo_level,
  input  logic [1:0][LVL_W-1:0]       fifo_thresh,
  input  logic [1:0]                  fifo_empty,
  input  logic [1:0]                  fifo_full,
  input  logic [1:0]                  op_reset,
  input  logic [1:0]                  op_dealloc,
  input  logic [1:0]                  op_retry,
  input  logic [1:0]                  op_discard,
  input  logic [1:0]                  op_commit,
  output logic [NCH-1:0]              dma_trig
);

  ev_vec_t [NFIFO-1:0] evs;
  logic [SEL_W-1:0]    sel_all [NCH];

  for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
    fdt_event_detect #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_det (
      .clk        (clk),
      .rst        (rst),
      .rd         (fifo_rd[f]),
      .wr         (fifo_wr[f]),
      .level      (fifo_level[f]),
      .thresh     (fifo_thresh[f]),
      .empty      (fifo_empty[f]),
      .full       (fifo_full[f]),
      .op_reset   (op_reset[f]),
      .op_dealloc (op_dealloc[f]),
      .op_retry   (op_retry[f]),
      .op_discard (op_discard[f]),
      .op_commit  (op_commit[f]),
      .events     (evs[f])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    fdt_chan #(.ADDR_W(ADDR_W), .CH_IDX(c)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .evs       (evs),
      .sel_o     (sel_all[c]),
      .trig_o    (dma_trig[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (int'(cfg_addr) < NCH) begin
      cfg_rdata <= {{(8-SEL_W){1'b0}}, sel_all[cfg_addr]};
    end else begin
      cfg_rdata <= '0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (dma_trig == '0) && (cfg_rdata == '0));

  // R2
  rdata_upper_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[7:SEL_W] == '0);

endmodule

// File: tb/fifo_evt_trigsel_test.sv
module fifo_evt_trigsel_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int NCH = 2;
  localparam int LW = $clog2(DEPTH+1);

  typedef struct {
    logic [1:0] trig;
    string      req;
    bit         chk_rd;
    logic [7:0] rd;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [0:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [1:0] rd = '0, wr = '0, emp = 2'b11, ful = '0;
  logic [1:0][LW-1:0] lvl = '0, thr = '0;
  logic [1:0] o_rst = '0, o_dea = '0, o_ret = '0, o_dis = '0, o_com = '0;
  logic [NCH-1:0] dma_trig;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_evt_trigsel #(.DEPTH(DEPTH), .NCH(NCH)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fifo_rd(rd), .fifo_wr(wr), .fifo_level(lvl), .fifo_thresh(thr),
    .fifo_empty(emp), .fifo_full(ful),
    .op_reset(o_rst), .op_dealloc(o_dea), .op_retry(o_ret),
    .op_discard(o_dis), .op_commit(o_com), .dma_trig(dma_trig)
  );

  // monitor: compare results just after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (dma_trig !== it.trig) begin
        n_bad++;
        $display("FAIL %s trig actual=%b expected=%b", it.req, dma_trig, it.trig);
      end
      if (it.chk_rd) begin
        n_chk++;
        if (cfg_rdata !== it.rd) begin
          n_bad++;
          $display("FAIL %s rdata actual=%h expected=%h", it.req, cfg_rdata, it.rd);
        end
      end
    end
  end

  // driver: push expectation, advance one cycle, clear strobes
  task automatic go(input logic [1:0] t, input string r, input bit c = 0, input logic [7:0] d = '0);
    item_t it;
    it.trig = t; it.req = r; it.chk_rd = c; it.rd = d;
    q.push_back(it);
    @(negedge clk);
    cfg_we = 0; rd = '0; wr = '0;
    o_rst = '0; o_dea = '0; o_ret = '0; o_dis = '0; o_com = '0;
  endtask

  task automatic wcfg(input int ch, input logic [7:0] v);
    cfg_we = 1; cfg_addr = 1'(ch); cfg_wdata = v;
    go(2'b00, "R2");
  endtask

  task automatic fire_op(input int side, input int k);
    case (k)
      0: o_rst[side] = 1;
      1: o_dea[side] = 1;
      2: o_ret[side] = 1;
      3: o_dis[side] = 1;
      default: o_com[side] = 1;
    endcase
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: outputs quiet, register reads zero
    cfg_addr = 0; go(2'b00, "R1");
    go(2'b00, "R1", 1, 8'h00);
    cfg_addr = 1; go(2'b00, "R1", 1, 8'h00);

    // R2: upper bits dropped, per-channel storage
    wcfg(0, 8'hE1);
    wcfg(1, 8'h12);
    cfg_addr = 0; go(2'b00, "R2", 1, 8'h01);
    cfg_addr = 1; go(2'b00, "R2", 1, 8'h12);

    // R4 on rx (ch0)
    rd[0] = 1; lvl[0] = 3; go(2'b01, "R4");
    rd[0] = 1; lvl[0] = 1; go(2'b00, "R4");
    wr[0] = 1; lvl[0] = 0; go(2'b01, "R4");
    wr[0] = 1; lvl[0] = 2; go(2'b00, "R4");
    // R3: tx read does not fire rx-selected ch0; ch1 tx space: read at level 3 no
    rd[1] = 1; lvl[1] = 3; go(2'b00, "R3");
    // R5 on tx (ch1)
    wr[1] = 1; lvl[1] = 3; go(2'b10, "R5");
    wr[1] = 1; lvl[1] = 7; go(2'b00, "R5");
    rd[1] = 1; lvl[1] = 8; go(2'b10, "R5");
    rd[1] = 1; lvl[1] = 5; go(2'b00, "R5");
    // R11: both channels in the same cycle, then quiet
    rd[0] = 1; lvl[0] = 3; wr[1] = 1; lvl[1] = 0; go(2'b11, "R11");
    go(2'b00, "R11");

    // R7 / R8
    wcfg(0, 8'h05); wcfg(1, 8'h16);
    thr[0] = 4; thr[1] = 2;
    wr[0] = 1; lvl[0] = 3; go(2'b01, "R7");
    wr[0] = 1; lvl[0] = 4; go(2'b00, "R7");
    rd[0] = 1; lvl[0] = 5; go(2'b00, "R7");
    wr[0] = 1; rd[0] = 1; lvl[0] = 4; go(2'b01, "R7");
    rd[1] = 1; lvl[1] = 2; go(2'b10, "R8");
    rd[1] = 1; lvl[1] = 3; go(2'b00, "R8");
    wr[1] = 1; lvl[1] = 2; go(2'b00, "R8");

    // R6: edges of empty / full
    wcfg(0, 8'h03); wcfg(1, 8'h14);
    emp[0] = 0; go(2'b00, "R6");
    emp[0] = 1; go(2'b01, "R6");
    go(2'b00, "R6");
    ful[1] = 1; go(2'b10, "R6");
    go(2'b00, "R6");
    go(2'b00, "R6");
    ful[1] = 0; go(2'b00, "R6");
    ful[0] = 1; go(2'b00, "R3");
    ful[0] = 0; go(2'b00, "R3");

    // R9: operation strobes in order 0x7..0xB
    for (int k = 0; k < 5; k++) begin
      wcfg(0, 8'(8'h07 + k)); wcfg(1, 8'(8'h17 + k));
      fire_op(0, k); go(2'b01, "R9");
      fire_op(1, k); go(2'b10, "R9");
      fire_op(0, (k + 1) % 5); fire_op(1, (k + 4) % 5); go(2'b00, "R9");
    end

    // R10: never codes under full stimulus
    for (int k = 0; k < 5; k++) begin
      logic [3:0] nb;
      nb = (k == 0) ? 4'h0 : 4'(4'hB + k);
      wcfg(0, {4'h0, nb}); wcfg(1, {4'h1, nb});
      thr = {4'd3, 4'd3};
      rd = 2'b11; lvl = {4'd3, 4'd3}; emp = 2'b00;
      o_rst = 2'b11; o_dea = 2'b11; o_ret = 2'b11; o_dis = 2'b11; o_com = 2'b11;
      go(2'b00, "R10");
      wr = 2'b11; lvl = {4'd0, 4'd0}; emp = 2'b11; ful = 2'b11;
      go(2'b00, "R10");
      ful = 2'b00; go(2'b00, "R10");
    end

    // R1: reset mid-run clears selections
    wcfg(0, 8'h0B);
    rst = 1; go(2'b00, "R1");
    rst = 0; cfg_addr = 0; go(2'b00, "R1");
    o_com[0] = 1; go(2'b00, "R1", 1, 8'h00);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule